// File: doc/BRIEF.md
# Vectoring CORDIC Magnitude Serializer

This block takes one frame of eight complex results, each a signed 12-bit real part and a signed 12-bit imaginary part, and turns them into eight unsigned 12-bit magnitudes. All eight bins run through the same number of shift-and-add vectoring iterations side by side. Each iteration pushes the imaginary part toward zero and grows the real part, which ends up holding the magnitude times a fixed gain. A bin whose real part is negative is turned by half a turn first, by negating both parts. The gain is then removed with a constant multiply, and the result is rounded and clipped to 12 bits.

A one-cycle load pulse captures the frame. Eight iteration cycles follow. The magnitudes then leave on a single 12-bit port, one bin per clock with bin 0 first, while a valid flag is high. A counter picks the bin through a multiplexer. The block accepts no new frame until the stream has ended. Loads that arrive earlier are dropped.

Top module: `mag_serializer`

## Requirements
- R1: After reset, and before any load, `magValid` is 0 and `magOut` is 0.
- R2: When `loadStrobe` is sampled high at rising edge n while the block is idle, `magValid` stays 0 after edges n+1 through n+7 and is 1 after edge n+8.
- R3: For a bin with a non-negative real part, the streamed value is within 2 LSB of round(sqrt(re^2+im^2)). Both parts are two's-complement signed 12-bit values.
- R4: For a bin with a negative real part, the streamed value also meets the 2 LSB bound of R3.
- R5: Bin k is taken from bits [12k+11:12k] of `reIn` and `imIn` and appears in the k-th valid cycle, counting from 0.
- R6: `magValid` is high for exactly 8 consecutive cycles per accepted load. Whenever `magValid` is 0, `magOut` is 0.
- R7: A `loadStrobe` sampled while a frame is iterating or streaming has no effect. The stream in progress is unchanged and no second stream follows it. This includes a load sampled at the edge that ends the last valid cycle.
- R8: Extreme inputs are handled: (-2048,-2048) gives about 2896, full-scale values on either axis give about 2048, and (0,0) gives 0. All of these meet the 2 LSB bound.
- R9: A load sampled at the first edge after the stream ends is accepted. Its frame streams with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Frame capture request, honoured only when idle |
| reIn | input | 96 | Real parts of bins 0..7, 12 bits each, bin k at [12k+11:12k] |
| imIn | input | 96 | Imaginary parts of bins 0..7, same packing |
| magOut | output | 12 | Streamed magnitude, zero when not valid |
| magValid | output | 1 | High while `magOut` carries a bin |

## Verification
The two functions that can meet in one cycle are streaming out a finished frame and a request to capture a new one. The bench raises `loadStrobe` in the middle of a stream, with different data on the inputs. It then raises it again in the final valid cycle. It judges the result by comparing every streamed bin against magnitudes computed from the first frame, and by checking that `magValid` is low after the stream. A load placed at the first idle edge right after a stream must start a new frame with normal timing.

// File: rtl/mag_pkg.sv
package mag_pkg;
  // counter width shared by control and datapath; covers up to 16 iterations / bins
  localparam int CTRL_CNT_W = 4;
  // reciprocal CORDIC gain (about 0.60725) in unsigned Q0.12, valid for ~8 or more iterations
  localparam int INV_GAIN_Q12 = 2487;
  localparam int INV_GAIN_FRAC = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ITER   = 2'd1,
    ST_STREAM = 2'd2
  } phase_t;

  typedef struct packed {
    logic                  captureEn;
    logic                  iterEn;
    logic [CTRL_CNT_W-1:0] shiftAmt;
    logic [CTRL_CNT_W-1:0] outSel;
    logic                  outValid;
  } ctrl_t;
endpackage

// File: rtl/mag_lane.sv
module mag_lane
  import mag_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 4,
  parameter int WORK_W = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     captureEn,
  input  logic                     iterEn,
  input  logic [CTRL_CNT_W-1:0]    shiftAmt,
  input  logic [DATA_W-1:0]        reIn,
  input  logic [DATA_W-1:0]        imIn,
  output logic signed [WORK_W-1:0] xOut
);
  logic signed [WORK_W-1:0] reExt, imExt, xInit, yInit;
  logic signed [WORK_W-1:0] xReg, yReg, xShift, yShift;
  logic                     leftHalf;

  assign reExt = {{(WORK_W-DATA_W-FRAC_W){reIn[DATA_W-1]}}, reIn, {FRAC_W{1'b0}}};
  assign imExt = {{(WORK_W-DATA_W-FRAC_W){imIn[DATA_W-1]}}, imIn, {FRAC_W{1'b0}}};

  // half-turn pre-rotation keeps the vector in the right half plane
  assign leftHalf = reExt[WORK_W-1];
  assign xInit    = leftHalf ? -reExt : reExt;
  assign yInit    = leftHalf ? -imExt : imExt;

  assign xShift = xReg >>> shiftAmt;
  assign yShift = yReg >>> shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else if (captureEn) begin
      xReg <= xInit;
      yReg <= yInit;
    end else if (iterEn) begin
      if (yReg[WORK_W-1]) begin
        xReg <= xReg - yShift;
        yReg <= yReg + xShift;
      end else begin
        xReg <= xReg + yShift;
        yReg <= yReg - xShift;
      end
    end
  end

  assign xOut = xReg;
endmodule

// File: rtl/mag_ctrl.sv
module mag_ctrl
  import mag_pkg::*;
#(
  parameter int NUM_BINS = 8,
  parameter int NUM_ITER = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  loadStrobe,
  output ctrl_t ctrl
);
  localparam logic [CTRL_CNT_W-1:0] LAST_ITER = CTRL_CNT_W'(NUM_ITER - 1);
  localparam logic [CTRL_CNT_W-1:0] LAST_BIN  = CTRL_CNT_W'(NUM_BINS - 1);

  phase_t                phase, phaseNext;
  logic [CTRL_CNT_W-1:0] cnt, cntNext;

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    case (phase)
      ST_IDLE: begin
        if (loadStrobe) begin
          phaseNext = ST_ITER;
          cntNext   = '0;
        end
      end
      ST_ITER: begin
        if (cnt == LAST_ITER) begin
          phaseNext = ST_STREAM;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_STREAM: begin
        if (cnt == LAST_BIN) begin
          phaseNext = ST_IDLE;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: begin
        phaseNext = ST_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    ctrl.captureEn = (phase == ST_IDLE) && loadStrobe;
    ctrl.iterEn    = (phase == ST_ITER);
    ctrl.shiftAmt  = cnt;
    ctrl.outSel    = cnt;
    ctrl.outValid  = (phase == ST_STREAM);
  end
endmodule

// File: rtl/mag_datapath.sv
module mag_datapath
  import mag_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_BINS = 8,
  parameter int FRAC_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_t                      ctrl,
  input  logic [NUM_BINS*DATA_W-1:0] reIn,
  input  logic [NUM_BINS*DATA_W-1:0] imIn,
  output logic [DATA_W-1:0]          magOut
);
  localparam int WORK_W = DATA_W + 3 + FRAC_W;
  localparam int SEL_W  = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
  localparam int PROD_W = WORK_W + INV_GAIN_FRAC;
  localparam int DROP_W = INV_GAIN_FRAC + FRAC_W;
  localparam logic [PROD_W-1:0] ROUND_HALF = PROD_W'(1) << (DROP_W - 1);
  localparam logic [PROD_W-1:0] MAG_MAX    = PROD_W'((1 << DATA_W) - 1);

  logic signed [WORK_W-1:0] xArr [NUM_BINS];
  logic signed [WORK_W-1:0] xSel;
  logic [PROD_W-1:0]        scaled, rounded, whole;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_lane
    mag_lane #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .WORK_W(WORK_W)
    ) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .captureEn(ctrl.captureEn),
      .iterEn   (ctrl.iterEn),
      .shiftAmt (ctrl.shiftAmt),
      .reIn     (reIn[b*DATA_W +: DATA_W]),
      .imIn     (imIn[b*DATA_W +: DATA_W]),
      .xOut     (xArr[b])
    );
  end

  // counter-driven bin select
  assign xSel = xArr[ctrl.outSel[SEL_W-1:0]];

  // gain removal, round to nearest, clip to the output width
  assign scaled  = PROD_W'($unsigned(xSel)) * PROD_W'(INV_GAIN_Q12);
  assign rounded = scaled + ROUND_HALF;
  assign whole   = rounded >> DROP_W;

  always_comb begin
    if (!ctrl.outValid)        magOut = '0;
    else if (whole > MAG_MAX)  magOut = '1;
    else                       magOut = whole[DATA_W-1:0];
  end
endmodule

// File: rtl/mag_serializer.sv
module mag_serializer
  import mag_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_BINS = 8,
  parameter int NUM_ITER = 8,
  parameter int FRAC_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadStrobe,
  input  logic [NUM_BINS*DATA_W-1:0] reIn,
  input  logic [NUM_BINS*DATA_W-1:0] imIn,
  output logic [DATA_W-1:0]          magOut,
  output logic                       magValid
);
  ctrl_t ctrl;

  mag_ctrl #(
    .NUM_BINS(NUM_BINS),
    .NUM_ITER(NUM_ITER)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStrobe(loadStrobe),
    .ctrl      (ctrl)
  );

  mag_datapath #(
    .DATA_W  (DATA_W),
    .NUM_BINS(NUM_BINS),
    .FRAC_W  (FRAC_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .reIn  (reIn),
    .imIn  (imIn),
    .magOut(magOut)
  );

  assign magValid = ctrl.outValid;
endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int DATA_W   = 12,
  parameter int NUM_BINS = 8,
  parameter int NUM_ITER = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStrobe,
  input logic [DATA_W-1:0] magOut,
  input logic              magValid
);
  localparam int RUN_LEN = NUM_ITER + NUM_BINS;
  localparam int MAX_MAG = ((1 << (DATA_W - 1)) * 1415) / 1000 + 3;

  // independent frame-phase tracker built from port activity only
  int runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 runCnt <= 0;
    else if (runCnt == 0)      runCnt <= loadStrobe ? 1 : 0;
    else if (runCnt == RUN_LEN) runCnt <= 0;
    else                       runCnt <= runCnt + 1;
  end

  AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    magValid == (runCnt > NUM_ITER)); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !magValid |-> magOut == '0); // R6

  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && runCnt > NUM_ITER && runCnt < RUN_LEN) |=> magValid); // R7

  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    magValid |-> int'(magOut) <= MAX_MAG); // R3

  AST_VALID_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(magValid) |-> runCnt == 0); // R6
endmodule

bind mag_serializer mag_checker #(
  .DATA_W  (DATA_W),
  .NUM_BINS(NUM_BINS),
  .NUM_ITER(NUM_ITER)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadStrobe(loadStrobe),
  .magOut    (magOut),
  .magValid  (magValid)
);

// File: tb/sim_mag_serializer.sv
module sim_mag_serializer;
  localparam int W = 12;
  localparam int NB = 8;
  localparam int NFR = 3;

  localparam logic signed [W-1:0] TAB_RE [0:NFR*NB-1] = '{
     100,     0,  -100,     0,   300,  -300,  -300,   300,
    2047, -2048, -2048,     0,     1,  1000,    -5,  2047,
      12,    -7,  1500,    -1,     0,   640, -2000,    33};
  localparam logic signed [W-1:0] TAB_IM [0:NFR*NB-1] = '{
       0,   100,     0,  -100,   400,   400,  -400,  -400,
       0, -2048,  2047,     0,     1,    -1,    12,  2047,
       5,   -24,  -800,     0, -2048,  -480,   100,    56};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            loadStrobe = 1'b0;
  logic [NB*W-1:0] reIn = '0;
  logic [NB*W-1:0] imIn = '0;
  logic [W-1:0]    magOut;
  logic            magValid;

  int errors = 0;
  int checks = 0;
  logic signed [W-1:0] curRe [NB];
  logic signed [W-1:0] curIm [NB];

  always #5 clk = ~clk;

  mag_serializer u0 (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe),
    .reIn(reIn), .imIn(imIn), .magOut(magOut), .magValid(magValid)
  );

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkVal(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: magOut actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refMag(input int r, input int i);
    return $rtoi($sqrt(real'(r * r + i * i)) + 0.5);
  endfunction

  // injectAt: stream cycle (0..7) at which a stray load with other data is raised, -1 for none
  task automatic runFrame(input string tag, input int injectAt);
    for (int b = 0; b < NB; b++) begin
      reIn[b*W +: W] = curRe[b];
      imIn[b*W +: W] = curIm[b];
    end
    loadStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadStrobe = 1'b0;
    for (int k = 1; k < 8; k++) begin
      checkBit("R2", magValid, 1'b0);
      @(posedge clk);
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      string req;
      req = (tag != "") ? tag : ((curRe[b] < 0) ? "R4" : "R3");
      checkBit("R6", magValid, 1'b1);
      checkVal(req, int'(magOut), refMag(int'(curRe[b]), int'(curIm[b])), 2);
      if (b == injectAt || (injectAt >= 0 && b == NB - 1)) begin
        reIn = {NB{12'sd900}};
        imIn = {NB{-12'sd700}};
        loadStrobe = 1'b1; // R7 stray load during stream
      end else begin
        loadStrobe = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      loadStrobe = 1'b0;
    end
    checkBit("R6", magValid, 1'b0);
    checkVal("R6", int'(magOut), 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkBit("R1", magValid, 1'b0);
    checkVal("R1", int'(magOut), 0, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkBit("R1", magValid, 1'b0);
    checkVal("R1", int'(magOut), 0, 0);

    // table-driven frames
    for (int f = 0; f < NFR; f++) begin
      for (int b = 0; b < NB; b++) begin
        curRe[b] = TAB_RE[f*NB + b];
        curIm[b] = TAB_IM[f*NB + b];
      end
      runFrame((f == 1) ? "R8" : "", -1);
    end

    // R5 bin order: one non-zero bin at a time
    for (int k = 0; k < NB; k += 3) begin
      for (int b = 0; b < NB; b++) begin
        curRe[b] = '0;
        curIm[b] = '0;
      end
      curIm[k] = -12'sd700 + 12'(k);
      runFrame("R5", -1);
    end

    // R7 stray loads mid-stream and in the last valid cycle
    for (int b = 0; b < NB; b++) begin
      curRe[b] = 12'(-50 * (b + 1));
      curIm[b] = 12'(37 * b);
    end
    runFrame("", 3);
    for (int k = 0; k < 4; k++) begin
      checkBit("R7", magValid, 1'b0);
      @(posedge clk);
      @(negedge clk);
    end

    // R9 load at the first idle edge after a stream
    for (int b = 0; b < NB; b++) begin
      curRe[b] = 12'(200 * b - 700);
      curIm[b] = 12'(150 - 90 * b);
    end
    runFrame("R9", -1);
    runFrame("R9", -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule